// File: doc/BRIEF.md
# Buffer Transfer Word Counter

This block sits between a host bus and a coprocessor's input and output FIFOs. It paces data movement with two host-programmed word counters. The input counter sets how many 32-bit words are handed from the input FIFO to the active execution unit. Once that many words have been handed over, the hand-off stops without further host action. The output counter sets how many processed words the host must still read back from the output FIFO. While that counter is nonzero, the block holds a DMA request asserted to prompt the reads.

A static mode pin sets the host burst length to four or eight words. Burst beats are accepted only at the two FIFO addresses. The block counts the beats and flags the final beat of each burst. A second DMA request, for transfers into the input buffer, is raised while input words are still owed and the input FIFO has room for a whole burst.

Top module: `xfer_word_counter`

## Requirements
- R1: After reset both counters read as zero, and `in_dreq`, `out_dreq`, `eu_pop` and `ofifo_pop` are low.
- R2: A single-beat host write to address 0x904 loads the input counter, and one to 0x906 loads the output counter. A single-beat read of either address returns the counter's current value on `host_rdata`.
- R3: `eu_pop` is high exactly when the input counter is nonzero, `eu_ready` is high and `ififo_nempty` is high. Each such cycle lowers the input counter by one, and no pop happens at zero.
- R4: `ofifo_pop` is high on a host read beat at the output FIFO address (0x880) only while the output counter is nonzero. Each pop lowers the counter by one. Read beats past zero pop nothing and return 0 on `host_rdata`.
- R5: `out_dreq` is high exactly while the output counter is nonzero.
- R6: `in_dreq` is high exactly while the input counter is nonzero and `in_free` is at least the burst length.
- R7: With `burst8` low the burst length is 4, and with it high the burst length is 8. `burst_last` is high on every burst-length-th burst beat at a FIFO address (input FIFO 0x800, output FIFO 0x880), counted from reset.
- R8: A burst beat aimed at a counter address writes nothing and reads as 0. Host writes at 0x800, single or burst, raise `ififo_push`.
- R9: A host load of a counter in the same cycle as its decrement takes priority, so the counter holds the written value.
- R10: Loading zero leaves that path idle: its DMA request is low and no pops occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst8 | input | 1 | Static mode: 0 = 4-word bursts, 1 = 8-word bursts |
| host_valid | input | 1 | Host beat present this cycle |
| host_we | input | 1 | Beat is a write |
| host_burst | input | 1 | Beat belongs to a burst |
| host_addr | input | 12 | Beat address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data |
| ofifo_rdata | input | 32 | Head word of the output FIFO |
| eu_ready | input | 1 | Execution unit can take a word |
| ififo_nempty | input | 1 | Input FIFO holds a word |
| in_free | input | 5 | Free word slots in the input FIFO |
| eu_pop | output | 1 | Move one word from the input FIFO to the unit |
| ofifo_pop | output | 1 | Pop one word from the output FIFO to the host |
| ififo_push | output | 1 | Push the host write data into the input FIFO |
| burst_last | output | 1 | Final beat of a FIFO burst |
| in_dreq | output | 1 | DMA request for input-buffer filling |
| out_dreq | output | 1 | DMA request for output-buffer draining |

## Verification
On every cycle the assertions check the step rules of both counters. A pop must lower its counter by exactly one, and no pop may occur at zero. A load must win over a decrement. The output request must stay up until a pop or a load, and the burst-end flag must never appear on two beats in a row. The bench scenarios are needed to show the whole sequences. These cover clipping of a read burst that runs past the count, a burst length that follows the mode pin, a burst aimed at a counter register being dropped, and the request thresholds against the free space in the input FIFO.

// File: rtl/xfer_word_counter.sv
module xfer_word_counter #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int FREE_W = 5,
  parameter logic [ADDR_W-1:0] IN_CNT_ADDR  = 12'h904,
  parameter logic [ADDR_W-1:0] OUT_CNT_ADDR = 12'h906,
  parameter logic [ADDR_W-1:0] IN_FIFO_ADDR  = 12'h800,
  parameter logic [ADDR_W-1:0] OUT_FIFO_ADDR = 12'h880
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst8,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic              host_burst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] ofifo_rdata,
  input  logic              eu_ready,
  input  logic              ififo_nempty,
  input  logic [FREE_W-1:0] in_free,
  output logic              eu_pop,
  output logic              ofifo_pop,
  output logic              ififo_push,
  output logic              burst_last,
  output logic              in_dreq,
  output logic              out_dreq
);
  logic [DATA_W-1:0] in_cnt, out_cnt;
  logic [2:0]        beat;

  wire hit_in_fifo  = host_addr == IN_FIFO_ADDR;
  wire hit_out_fifo = host_addr == OUT_FIFO_ADDR;
  wire reg_beat     = host_valid && !host_burst;
  wire wr_in        = reg_beat && host_we && host_addr == IN_CNT_ADDR;   // R2 R8
  wire wr_out       = reg_beat && host_we && host_addr == OUT_CNT_ADDR;
  wire fifo_beat    = host_valid && host_burst && (hit_in_fifo || hit_out_fifo);
  wire beat_end     = beat == (burst8 ? 3'd7 : 3'd3);                    // R7
  wire [FREE_W-1:0] burst_len = burst8 ? FREE_W'(8) : FREE_W'(4);

  assign eu_pop     = eu_ready && ififo_nempty && in_cnt != '0;          // R3
  assign ofifo_pop  = host_valid && !host_we && hit_out_fifo && out_cnt != '0; // R4
  assign ififo_push = host_valid && host_we && hit_in_fifo;
  assign burst_last = fifo_beat && beat_end;
  assign in_dreq    = in_cnt != '0 && in_free >= burst_len;              // R6
  assign out_dreq   = out_cnt != '0;                                     // R5

  always_comb begin
    host_rdata = '0;
    if (host_valid && !host_we) begin
      if (hit_out_fifo && out_cnt != '0) host_rdata = ofifo_rdata;
      else if (!host_burst && host_addr == IN_CNT_ADDR)  host_rdata = in_cnt;
      else if (!host_burst && host_addr == OUT_CNT_ADDR) host_rdata = out_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      out_cnt <= '0;
      beat    <= '0;
    end else begin
      if (wr_in)       in_cnt <= host_wdata;                             // R9
      else if (eu_pop) in_cnt <= in_cnt - 1'b1;
      if (wr_out)         out_cnt <= host_wdata;
      else if (ofifo_pop) out_cnt <= out_cnt - 1'b1;
      if (fifo_beat) beat <= beat_end ? 3'd0 : beat + 3'd1;
    end
  end
endmodule

module xfer_word_counter_chk #(parameter int DATA_W = 32) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] in_cnt,
  input logic [DATA_W-1:0] out_cnt,
  input logic              wr_in,
  input logic              wr_out,
  input logic [DATA_W-1:0] host_wdata,
  input logic              eu_pop,
  input logic              ofifo_pop,
  input logic              out_dreq,
  input logic              burst_last
);
  AST_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n) (eu_pop && !wr_in) |=> in_cnt == $past(in_cnt) - 1); // R3
  AST_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n) (in_cnt == '0) |-> !eu_pop); // R3
  AST_OUT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ofifo_pop && !wr_out) |=> out_cnt == $past(out_cnt) - 1); // R4
  AST_OUT_CLIP: assert property (@(posedge clk) disable iff (!rst_n) (out_cnt == '0) |-> !ofifo_pop); // R4
  AST_DREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_dreq && !ofifo_pop && !wr_out) |=> out_dreq); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n) wr_in |=> in_cnt == $past(host_wdata)); // R9
  AST_LAST_SPACED: assert property (@(posedge clk) disable iff (!rst_n) burst_last |=> !burst_last); // R7
endmodule

bind xfer_word_counter xfer_word_counter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .out_cnt(out_cnt),
  .wr_in(wr_in), .wr_out(wr_out), .host_wdata(host_wdata),
  .eu_pop(eu_pop), .ofifo_pop(ofifo_pop), .out_dreq(out_dreq),
  .burst_last(burst_last));

// File: tb/xfer_word_counter_bench.sv
module xfer_word_counter_bench;
  logic clk = 0, rst_n = 0, burst8 = 0;
  logic host_valid = 0, host_we = 0, host_burst = 0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0, ofifo_rdata = '0, host_rdata;
  logic eu_ready = 0, ififo_nempty = 0;
  logic [4:0] in_free = '0;
  logic eu_pop, ofifo_pop, ififo_push, burst_last, in_dreq, out_dreq;

  int vectors = 0, errors = 0;
  longint m_in = 0, m_out = 0;
  int m_beat = 0;

  always #4 clk = ~clk;

  xfer_word_counter u_xfer_word_counter (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit we, bit bu, logic [11:0] a, logic [31:0] wd,
                      bit er, bit ne, int fr);
    int bl;
    bit e_eu, e_op, fb, last;
    longint e_rd;
    @(negedge clk);
    host_valid = v; host_we = we; host_burst = bu; host_addr = a; host_wdata = wd;
    eu_ready = er; ififo_nempty = ne; in_free = 5'(fr);
    ofifo_rdata = 32'hD00D_0000 + 32'(vectors);
    #1;
    bl = burst8 ? 8 : 4;
    e_eu = er && ne && m_in != 0;
    e_op = v && !we && a == 12'h880 && m_out != 0;
    fb = v && bu && (a == 12'h800 || a == 12'h880);
    last = fb && m_beat == bl - 1;
    e_rd = 0;
    if (v && !we) begin
      if (a == 12'h880 && m_out != 0) e_rd = ofifo_rdata;
      else if (!bu && a == 12'h904) e_rd = m_in;
      else if (!bu && a == 12'h906) e_rd = m_out;
    end
    chk("R3", "eu_pop", eu_pop, e_eu);
    chk("R4", "ofifo_pop", ofifo_pop, e_op);
    chk("R5", "out_dreq", out_dreq, m_out != 0);
    chk("R6", "in_dreq", in_dreq, m_in != 0 && fr >= bl);
    chk("R7", "burst_last", burst_last, last);
    chk("R8", "ififo_push", ififo_push, v && we && a == 12'h800);
    chk("R2", "host_rdata", host_rdata, e_rd);
    @(posedge clk);
    if (rst_n) begin
      if (v && we && !bu && a == 12'h904) m_in = wd;
      else if (e_eu) m_in = m_in - 1;
      if (v && we && !bu && a == 12'h906) m_out = wd;
      else if (e_op) m_out = m_out - 1;
      if (fb) m_beat = last ? 0 : m_beat + 1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 12'h0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1;
    idle(1);                                            // R1 reset state
    step(1, 0, 0, 12'h904, 0, 0, 0, 0);                 // R1 readback zero
    step(1, 0, 0, 12'h906, 0, 1, 1, 31);
    // R2 R6 load input count, request thresholds
    step(1, 1, 0, 12'h904, 32'h10, 0, 0, 0);
    step(1, 0, 0, 12'h904, 0, 0, 0, 3);
    step(0, 0, 0, 0, 0, 0, 0, 4);
    // R3 drain to zero with gaps
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, i % 3 != 0, i % 5 != 0, 8);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, 1, 8);
    // R4 R5 R7 output count 6, two 4-beat read bursts, clipped
    step(1, 1, 0, 12'h906, 6, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 1, 12'h880, 0, 0, 0, 0);
    step(1, 0, 0, 12'h906, 0, 0, 0, 0);
    // R7 eight-beat bursts into input FIFO
    burst8 = 1;
    for (int i = 0; i < 16; i++) step(1, 1, 1, 12'h800, 32'(i), 0, 0, 8);
    step(1, 1, 0, 12'h800, 32'h55, 0, 0, 0);
    // R8 burst to a counter address dropped
    step(1, 1, 1, 12'h904, 32'h77, 0, 0, 0);
    step(1, 0, 1, 12'h904, 0, 0, 0, 0);
    step(1, 0, 0, 12'h904, 0, 0, 0, 0);
    // R9 load beats decrement
    step(1, 1, 0, 12'h904, 3, 1, 1, 8);
    step(1, 1, 0, 12'h904, 9, 1, 1, 8);
    step(1, 0, 0, 12'h904, 0, 1, 1, 8);
    step(1, 1, 0, 12'h906, 2, 0, 0, 0);
    step(1, 0, 0, 12'h880, 0, 0, 0, 0);
    // R9 R10 load zero idles both paths
    step(1, 1, 0, 12'h904, 0, 1, 1, 31);
    step(1, 1, 0, 12'h906, 0, 1, 1, 31);
    step(1, 0, 0, 12'h880, 0, 1, 1, 31);
    burst8 = 0;
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule